// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Lane Aligner

This block sits between a processor's load/store unit and a data memory that is one 32-bit word wide. For every request it decodes the access size and the two low address bits. On a store it moves the source register's low byte, halfword or whole word onto the memory lanes and raises only the byte enables of the addressed bytes, so the untouched bytes of the memory word keep their contents.

On a load, the memory returns its word one clock after the request. The block remembers the size, the offset and the signedness of the request for that cycle. It then picks the addressed byte or halfword out of the returned word and right-justifies it. Finally it extends the value to 32 bits, with the sign bit or with zeros.

Lanes follow big-endian order: the lowest byte address sits in the most significant lane. Requests whose offset does not suit their size are flagged and suppressed. The block does not raise an exception for them, because that is left to the core.

Top module: `laneAlign`

## Requirements
- R1: A byte load at offset k (k = 0..3) returns the returned word's bits [31-8k : 24-8k] in loadData[7:0].
- R2: For a byte load with reqSigned = 1, loadData[31:8] all equal bit 7 of the selected byte. With reqSigned = 0 they are zero.
- R3: A halfword load (reqSize = 1) at offset 0 returns bits 31:16, and at offset 2 returns bits 15:0, in loadData[15:0]. Bits 31:16 are a copy of bit 15 when reqSigned = 1 and zero when reqSigned = 0.
- R4: A word load (reqSize = 2) at offset 0 returns the memory word unchanged, whatever reqSigned is.
- R5: A valid byte store (reqSize = 0) at offset k drives exactly one byte enable, memByteEn bit 3-k. Enable bit i covers memWdata[8i+7:8i].
- R6: On a store, memWdata holds storeData[7:0] in all four lanes for a byte, storeData[15:0] in both halves for a halfword, and storeData itself for a word.
- R7: A valid halfword store drives memByteEn = 4'b1100 at offset 0 and 4'b0011 at offset 2. A valid word store drives 4'b1111.
- R8: misalign is 1 for a valid request that is a halfword at an odd offset, a word at a nonzero offset, or size code 3. Such a request drives no byte enables and produces no load result.
- R9: loadValid is 1 in exactly the cycle after an aligned load request and 0 otherwise. loadData is zero while loadValid is 0.
- R10: With no valid request, memByteEn is 0 and misalign is 0. During and right after reset, loadValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| reqSigned | input | 1 | Sign-extend a sub-word load |
| reqOffset | input | 2 | Byte offset of the access within the word |
| storeData | input | 32 | Source register value for stores |
| memWdata | output | 32 | Lane-positioned store data |
| memByteEn | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| misalign | output | 1 | Request offset does not suit its size |
| memRdata | input | 32 | Word returned by memory one cycle after a load |
| loadValid | output | 1 | Load result present |
| loadData | output | 32 | Aligned and extended load result |

## Verification
The assertions assume that memRdata carries the word for a load in the cycle after that load's request. They also assume that reqSize, reqOffset and reqSigned describe the access in the cycle reqValid is high. The bench drives every request for one cycle only and presents the memory word in the following cycle. It returns reqValid to 0 between accesses, so no two loads overlap. Every combination of size code, offset, signedness and direction is swept with data patterns whose sign bits differ from lane to lane.

// File: rtl/laneAlignPkg.sv
`timescale 1ns/1ps
package laneAlignPkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  // Strobes from control to datapath for the load-return cycle
  typedef struct packed {
    logic             loadValid;
    accSize_e         size;
    logic             signExt;
    logic [OFF_W-1:0] offset;
  } loadStrobe_t;
endpackage

// File: rtl/laneAlignCtrl.sv
`timescale 1ns/1ps
module laneAlignCtrl
  import laneAlignPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  accSize_e         reqSize,
  input  logic             reqSigned,
  input  logic [OFF_W-1:0] reqOffset,
  output logic [LANES-1:0] byteEn,
  output logic             misalign,
  output loadStrobe_t      loadStrobe
);
  localparam logic [OFF_W-1:0] TOP_LANE = OFF_W'(LANES - 1);
  localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
  localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

  logic             aligned;
  logic [LANES-1:0] laneMask;
  logic [OFF_W-1:0] laneSel;

  // Big-endian: offset 0 maps to the most significant lane
  assign laneSel = TOP_LANE - reqOffset;

  always_comb begin
    aligned  = 1'b0;
    laneMask = '0;
    unique case (reqSize)
      SZ_BYTE: begin
        aligned  = 1'b1;
        laneMask = ONE_LANE << laneSel;
      end
      SZ_HALF: begin
        aligned  = ~reqOffset[0];
        laneMask = TWO_LANE << (laneSel - OFF_W'(1));
      end
      SZ_WORD: begin
        aligned  = (reqOffset == '0);
        laneMask = '1;
      end
      default: begin
        aligned  = 1'b0;
        laneMask = '0;
      end
    endcase
  end

  assign misalign = reqValid & ~aligned;
  assign byteEn   = (reqValid & reqWrite & aligned) ? laneMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadStrobe <= '0;
    end else begin
      loadStrobe.loadValid <= reqValid & ~reqWrite & aligned;
      loadStrobe.size      <= reqSize;
      loadStrobe.signExt   <= reqSigned;
      loadStrobe.offset    <= reqOffset;
    end
  end
endmodule

// File: rtl/laneAlignData.sv
`timescale 1ns/1ps
module laneAlignData
  import laneAlignPkg::*;
(
  input  accSize_e          storeSize,
  input  logic [WORD_W-1:0] storeData,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  loadStrobe_t       loadStrobe,
  output logic [WORD_W-1:0] loadData
);
  localparam int HALVES = LANES / 2;

  logic [WORD_W-1:0] byteRep;
  logic [WORD_W-1:0] halfRep;

  // Replicate the source onto every lane an enable could select
  for (genvar g = 0; g < LANES; g++) begin : gByteRep
    assign byteRep[g*8 +: 8] = storeData[7:0];
  end
  for (genvar g = 0; g < HALVES; g++) begin : gHalfRep
    assign halfRep[g*16 +: 16] = storeData[15:0];
  end

  always_comb begin
    unique case (storeSize)
      SZ_BYTE: memWdata = byteRep;
      SZ_HALF: memWdata = halfRep;
      default: memWdata = storeData;
    endcase
  end

  logic [OFF_W-1:0]  byteLane;
  logic [OFF_W-1:0]  halfLane;
  logic [7:0]        pickByte;
  logic [15:0]       pickHalf;
  logic [WORD_W-1:0] shapedWord;

  assign byteLane = OFF_W'(LANES - 1) - loadStrobe.offset;
  assign halfLane = OFF_W'(LANES - 2) - {loadStrobe.offset[OFF_W-1:1], 1'b0};
  assign pickByte = 8'(memRdata >> {byteLane, 3'b000});
  assign pickHalf = 16'(memRdata >> {halfLane, 3'b000});

  always_comb begin
    unique case (loadStrobe.size)
      SZ_BYTE: shapedWord = {{(WORD_W-8){loadStrobe.signExt & pickByte[7]}}, pickByte};
      SZ_HALF: shapedWord = {{(WORD_W-16){loadStrobe.signExt & pickHalf[15]}}, pickHalf};
      SZ_WORD: shapedWord = memRdata;
      default: shapedWord = '0;
    endcase
  end

  assign loadData = loadStrobe.loadValid ? shapedWord : '0;
endmodule

// File: rtl/laneAlign.sv
`timescale 1ns/1ps
module laneAlign
  import laneAlignPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [WORD_W-1:0] storeData,
  output logic [WORD_W-1:0] memWdata,
  output logic [LANES-1:0]  memByteEn,
  output logic              misalign,
  input  logic [WORD_W-1:0] memRdata,
  output logic              loadValid,
  output logic [WORD_W-1:0] loadData
);
  accSize_e    sizeCode;
  loadStrobe_t loadStrobe;

  assign sizeCode = accSize_e'(reqSize);

  laneAlignCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (sizeCode),
    .reqSigned  (reqSigned),
    .reqOffset  (reqOffset),
    .byteEn     (memByteEn),
    .misalign   (misalign),
    .loadStrobe (loadStrobe)
  );

  laneAlignData i_data (
    .storeSize  (sizeCode),
    .storeData  (storeData),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .loadStrobe (loadStrobe),
    .loadData   (loadData)
  );

  assign loadValid = loadStrobe.loadValid;
endmodule

// File: rtl/laneAlignChecker.sv
`timescale 1ns/1ps
module laneAlignChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [1:0]  reqSize,
  input logic        reqSigned,
  input logic [1:0]  reqOffset,
  input logic [3:0]  memByteEn,
  input logic        misalign,
  input logic        loadValid,
  input logic [31:0] loadData
);
  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 2'd0) |-> $countones(memByteEn) == 1);

  assert_half_two_lanes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 2'd1 && !reqOffset[0]) |-> $countones(memByteEn) == 2);

  assert_misalign_no_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> memByteEn == 4'b0000);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (memByteEn == 4'b0000 && !misalign));

  assert_result_follows_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !misalign) |=> loadValid);

  assert_no_result_without_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite && !misalign) |=> !loadValid);

  assert_zero_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> loadData == 32'd0);

  assert_byte_unsigned_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd0 && !reqSigned) |=> loadData[31:8] == 24'd0);

  assert_half_signed_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd1 && reqSigned && !misalign) |=>
      loadData[31:16] == {16{loadData[15]}});
endmodule

bind laneAlign laneAlignChecker i_laneAlignChecker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqSize   (reqSize),
  .reqSigned (reqSigned),
  .reqOffset (reqOffset),
  .memByteEn (memByteEn),
  .misalign  (misalign),
  .loadValid (loadValid),
  .loadData  (loadData)
);

// File: tb/test_laneAlign.sv
`timescale 1ns/1ps
module test_laneAlign;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqSigned = 1'b0;
  logic [1:0]  reqOffset = 2'd0;
  logic [31:0] storeData = 32'd0;
  logic [31:0] memWdata;
  logic [3:0]  memByteEn;
  logic        misalign;
  logic [31:0] memRdata = 32'd0;
  logic        loadValid;
  logic [31:0] loadData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  laneAlign i_laneAlign (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqOffset(reqOffset),
    .storeData(storeData), .memWdata(memWdata), .memByteEn(memByteEn),
    .misalign(misalign), .memRdata(memRdata), .loadValid(loadValid),
    .loadData(loadData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit expMis(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0: return 1'b0;
      2'd1: return off[0];
      2'd2: return off != 2'd0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] expLoad(input logic [1:0] sz, input logic [1:0] off,
                                          input bit sgn, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = 8'((w >> (8 * (3 - int'(off)))) & 32'hFF);
    h = 16'((w >> (8 * (2 - int'(off)))) & 32'hFFFF);
    case (sz)
      2'd0: return (sgn && b[7]) ? (32'hFFFFFF00 | 32'(b)) : 32'(b);
      2'd1: return (sgn && h[15]) ? (32'hFFFF0000 | 32'(h)) : 32'(h);
      default: return w;
    endcase
  endfunction

  function automatic logic [3:0] expEn(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0: return 4'(1 << (3 - int'(off)));
      2'd1: return (off == 2'd0) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] expWdata(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0: return {4{d[7:0]}};
      2'd1: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  task automatic doStore(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] d);
    bit mis;
    mis = expMis(sz, off);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqSize = sz; reqOffset = off;
    reqSigned = 1'b0; storeData = d;
    #1;
    check(misalign == mis, "R8 store misalign", 32'(misalign), 32'(mis));
    if (mis) begin
      check(memByteEn == 4'b0, "R8 misaligned store enables", 32'(memByteEn), 32'd0);
    end else begin
      if (sz == 2'd0)
        check(memByteEn == expEn(sz, off), "R5 byte store enable", 32'(memByteEn), 32'(expEn(sz, off)));
      else
        check(memByteEn == expEn(sz, off), "R7 wide store enable", 32'(memByteEn), 32'(expEn(sz, off)));
      check(memWdata == expWdata(sz, d), "R6 store data lanes", memWdata, expWdata(sz, d));
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(loadValid == 1'b0, "R9 no result after store", 32'(loadValid), 32'd0);
    check(memByteEn == 4'b0 && !misalign, "R10 idle quiet", {27'd0, misalign, memByteEn}, 32'd0);
  endtask

  task automatic doLoad(input logic [1:0] sz, input logic [1:0] off, input bit sgn, input logic [31:0] w);
    bit mis;
    logic [31:0] exp;
    mis = expMis(sz, off);
    exp = expLoad(sz, off, sgn, w);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = sz; reqOffset = off; reqSigned = sgn;
    memRdata = ~w;
    #1;
    check(misalign == mis, "R8 load misalign", 32'(misalign), 32'(mis));
    check(memByteEn == 4'b0, "R10 load drives no enables", 32'(memByteEn), 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    memRdata = w;
    #1;
    check(loadValid == !mis, "R9 R8 load result valid", 32'(loadValid), 32'(!mis));
    if (mis) begin
      check(loadData == 32'd0, "R8 R9 misaligned load data", loadData, 32'd0);
    end else begin
      case (sz)
        2'd0: check(loadData == exp, "R1 R2 byte load", loadData, exp);
        2'd1: check(loadData == exp, "R3 halfword load", loadData, exp);
        default: check(loadData == exp, "R4 word load", loadData, exp);
      endcase
    end
    @(negedge clk);
    #1;
    check(loadValid == 1'b0 && loadData == 32'd0, "R9 result lasts one cycle", loadData, 32'd0);
  endtask

  initial begin
    logic [31:0] words [3];
    logic [31:0] srcs [2];
    words[0] = 32'h80FF7F01;
    words[1] = 32'h7F8001FE;
    words[2] = 32'hA5C33C5A;
    srcs[0]  = 32'h123456F7;
    srcs[1]  = 32'hCAFE8001;

    repeat (3) @(negedge clk);
    #1;
    check(loadValid == 1'b0, "R10 reset loadValid", 32'(loadValid), 32'd0);
    check(memByteEn == 4'b0 && !misalign, "R10 reset outputs", {27'd0, misalign, memByteEn}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(loadValid == 1'b0, "R10 after reset loadValid", 32'(loadValid), 32'd0);

    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int p = 0; p < 2; p++)
          doStore(2'(s), 2'(o), srcs[p]);

    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int g = 0; g < 2; g++)
          for (int p = 0; p < 3; p++)
            doLoad(2'(s), 2'(o), bit'(g), words[p]);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule